// File: doc/BRIEF.md
# Multicast Fat-Tree Distribution Network

This block carries operand words (weights or input activations) from a buffer-side root to a row of multiplier leaves. It is a binary tree of small forwarding switches. Each switch passes a word to its left child, its right child, or both, so one word can reach any subset of the leaves in a single pass. Every word carries an N-bit destination mask, and bit `i` of that mask selects leaf `i`.

The root accepts up to B words per cycle on B injection lanes. The links near the root are wider than the links near the leaves: a node whose subtree covers S leaves carries min(B, S) parallel word slots. Because of this, several multicasts can travel down the tree in the same cycles and arrive at their leaves together. Each tree level has one register stage, so every accepted word reaches its leaves exactly log2(N) cycles after it is injected.

If two words injected in the same cycle name the same leaf, the lower-numbered lane is accepted. The higher lane sees its ready flag low and must hold its word. Typical settings are B of 1, 4 or 16, with 32 or 64 leaves.

Top module: `mcast_fat_tree`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, every leaf valid output is low. A reset asserted while words are in flight discards them, so none of them is delivered.
- R2: A word accepted in cycle c with a single mask bit set appears at that leaf with its data unchanged in cycle c+log2(N). The leaf valid is high for exactly that one cycle.
- R3: A word whose mask has several bits set is delivered in the same cycle to every leaf whose bit is set, and to no other leaf.
- R4: A word with an all-zero mask is accepted (its ready is high) and delivers nothing to any leaf.
- R5: Up to B words on different lanes with pairwise disjoint masks are all accepted in one cycle. All of them are delivered in the same later cycle, with no word dropped inside the tree.
- R6: When the masks of two valid words in one cycle share a leaf, the lower-numbered lane is accepted. The higher lane's ready is low, and its word reaches no leaf.
- R7: A lane's ready depends only on the masks of lower lanes that are both valid and accepted. A lane that is invalid, or was itself blocked, blocks nobody.
- R8: Lane 0 is always ready.
- R9: Words accepted in consecutive cycles are delivered in consecutive cycles, giving one word per lane per cycle of throughput.
- R10: Leaf index equals mask bit index: bit 0 addresses leaf 0, and bit N-1 addresses leaf N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | LANES | Per-lane word valid |
| in_data | input | LANES*DW | Per-lane word payload |
| in_mask | input | LANES*N_LEAVES | Per-lane destination leaf mask (bit i = leaf i) |
| in_rdy | output | LANES | Per-lane accept flag; a valid word with ready low must be held |
| leaf_vld | output | N_LEAVES | One-cycle delivery strobe per leaf |
| leaf_data | output | N_LEAVES*DW | Delivered word per leaf |

## Verification
The bench targets five corner cases.

- **Overlap arbitration.** A design that let a blocked higher lane keep claiming leaves would wrongly refuse a third lane that overlaps only the blocked one.
- **Invalid lower lane.** A lane whose valid is low still presents a mask. If the arbiter counted that mask, it would stall the lanes above it.
- **Extreme leaves and multicast spread.** Leaf 31, the all-ones mask and a scattered mask expose off-by-one errors in the subtree split, which would deliver to a neighbouring leaf or miss one.
- **Full-width injection.** Four disjoint lanes at full width stress the slot compaction in the narrowed lower levels, where a word could be dropped.
- **Timing.** Back-to-back words to the same leaf show a stage that holds data for more than one cycle. A reset during flight shows pipeline registers that are not cleared.

// File: rtl/mft_pkg.sv
package mft_pkg;

    // Parallel word slots carried by a node at the given depth (fat-tree width).
    function automatic int slot_width(input int lanes, input int leaves, input int depth);
        int sub;
        sub = leaves >> depth;
        return (lanes < sub) ? lanes : sub;
    endfunction

endpackage

// File: rtl/mft_root_arb.sv
module mft_root_arb #(
    parameter int LANES = 4,
    parameter int N     = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          vld_i,
    input  logic [LANES-1:0][N-1:0]   mask_i,
    output logic [LANES-1:0]          rdy_o,
    output logic [LANES-1:0]          acc_o
);

    logic [N-1:0] claimed;

    always_comb begin
        claimed = '0;
        rdy_o   = '0;
        acc_o   = '0;
        for (int k = 0; k < LANES; k++) begin
            rdy_o[k] = ((mask_i[k] & claimed) == '0);
            if (vld_i[k] && rdy_o[k]) begin
                acc_o[k] = 1'b1;
                claimed  = claimed | mask_i[k];
            end
        end
    end

    // R8
    lane0_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) rdy_o[0]);

    for (genvar a = 0; a < LANES; a++) begin : g_pa
        for (genvar b = a + 1; b < LANES; b++) begin : g_pb
            // R6
            acc_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_o[a] && acc_o[b]) |-> ((mask_i[a] & mask_i[b]) == '0));
        end
    end

endmodule

// File: rtl/mft_level.sv
module mft_level #(
    parameter int N     = 32,
    parameter int DW    = 16,
    parameter int DEPTH = 1,
    parameter int WI    = 4,
    parameter int WO    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [(1<<(DEPTH-1))*WI-1:0]            in_vld,
    input  logic [(1<<(DEPTH-1))*WI-1:0][DW-1:0]    in_data,
    input  logic [(1<<(DEPTH-1))*WI-1:0][N-1:0]     in_mask,
    output logic [(1<<DEPTH)*WO-1:0]                out_vld,
    output logic [(1<<DEPTH)*WO-1:0][DW-1:0]        out_data,
    output logic [(1<<DEPTH)*WO-1:0][N-1:0]         out_mask
);

    localparam int NO  = 1 << DEPTH;
    localparam int SUB = N >> DEPTH;
    localparam int SO  = NO * WO;

    function automatic logic [NO-1:0][N-1:0] build_cover();
        logic [NO-1:0][N-1:0] r;
        r = '0;
        for (int c = 0; c < NO; c++)
            for (int b = 0; b < N; b++)
                r[c][b] = ((b / SUB) == c);
        return r;
    endfunction

    localparam logic [NO-1:0][N-1:0] COVER = build_cover();

    typedef struct packed {
        logic [SO-1:0]          vld;
        logic [SO-1:0][DW-1:0]  data;
        logic [SO-1:0][N-1:0]   mask;
    } stage_t;

    stage_t st_d, st_q;
    logic   slot_ovf;

    always_comb begin
        int           fill;
        logic [N-1:0] part;
        st_d     = '0;
        slot_ovf = 1'b0;
        for (int c = 0; c < NO; c++) begin
            fill = 0;
            for (int s = 0; s < WI; s++) begin
                part = in_mask[(c/2)*WI + s] & COVER[c];
                if (in_vld[(c/2)*WI + s] && (part != '0)) begin
                    if (fill < WO) begin
                        st_d.vld[c*WO + fill]  = 1'b1;
                        st_d.data[c*WO + fill] = in_data[(c/2)*WI + s];
                        st_d.mask[c*WO + fill] = part;
                        fill = fill + 1;
                    end else begin
                        slot_ovf = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;
    assign out_mask = st_q.mask;

    // R5
    no_slot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) !slot_ovf);

    for (genvar k = 0; k < SO; k++) begin : g_slot
        // R4
        live_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[k] |-> (out_mask[k] != '0));
        // R3
        in_subtree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[k] |-> ((out_mask[k] & ~COVER[k/WO]) == '0));
    end

endmodule

// File: rtl/mcast_fat_tree.sv
module mcast_fat_tree
    import mft_pkg::*;
#(
    parameter int N_LEAVES = 32,
    parameter int LANES    = 4,
    parameter int DW       = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LANES-1:0]                  in_vld,
    input  logic [LANES-1:0][DW-1:0]          in_data,
    input  logic [LANES-1:0][N_LEAVES-1:0]    in_mask,
    output logic [LANES-1:0]                  in_rdy,
    output logic [N_LEAVES-1:0]               leaf_vld,
    output logic [N_LEAVES-1:0][DW-1:0]       leaf_data
);

    localparam int LEVELS = $clog2(N_LEAVES);

    logic [LANES-1:0] acc;

    mft_root_arb #(.LANES(LANES), .N(N_LEAVES)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .mask_i (in_mask),
        .rdy_o  (in_rdy),
        .acc_o  (acc)
    );

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        localparam int WI = slot_width(LANES, N_LEAVES, l - 1);
        localparam int WO = slot_width(LANES, N_LEAVES, l);
        localparam int SI = (1 << (l - 1)) * WI;
        localparam int SO = (1 << l) * WO;

        logic [SI-1:0]                 i_vld;
        logic [SI-1:0][DW-1:0]         i_data;
        logic [SI-1:0][N_LEAVES-1:0]   i_mask;
        logic [SO-1:0]                 o_vld;
        logic [SO-1:0][DW-1:0]         o_data;
        logic [SO-1:0][N_LEAVES-1:0]   o_mask;

        if (l == 1) begin : g_src
            assign i_vld  = acc;
            assign i_data = in_data;
            assign i_mask = in_mask;
        end else begin : g_src
            assign i_vld  = g_lvl[l-1].o_vld;
            assign i_data = g_lvl[l-1].o_data;
            assign i_mask = g_lvl[l-1].o_mask;
        end

        mft_level #(
            .N(N_LEAVES), .DW(DW), .DEPTH(l), .WI(WI), .WO(WO)
        ) u_lvl (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (i_vld),
            .in_data  (i_data),
            .in_mask  (i_mask),
            .out_vld  (o_vld),
            .out_data (o_data),
            .out_mask (o_mask)
        );
    end

    assign leaf_vld  = g_lvl[LEVELS].o_vld;
    assign leaf_data = g_lvl[LEVELS].o_data;

endmodule

// File: tb/mcast_fat_tree_test.sv
module mcast_fat_tree_test;

    localparam int N  = 32;
    localparam int B  = 4;
    localparam int DW = 16;
    localparam int LV = 5;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [B-1:0]           in_vld = '0;
    logic [B-1:0][DW-1:0]   in_data = '0;
    logic [B-1:0][N-1:0]    in_mask = '0;
    logic [B-1:0]           in_rdy;
    logic [N-1:0]           leaf_vld;
    logic [N-1:0][DW-1:0]   leaf_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mcast_fat_tree #(.N_LEAVES(N), .LANES(B), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .in_mask(in_mask), .in_rdy(in_rdy), .leaf_vld(leaf_vld), .leaf_data(leaf_data)
    );

    typedef struct packed {
        logic [B-1:0]        v;
        logic [B-1:0][N-1:0] m;
        logic [B-1:0]        rdy;
        logic [N-1:0]        lv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        // R2 unicast to leaf 0
        '{4'b0001, {32'h0, 32'h0, 32'h0, 32'h0000_0001}, 4'b1111, 32'h0000_0001},
        // R10 leaf 31 through lane 2
        '{4'b0100, {32'h0, 32'h8000_0000, 32'h0, 32'h0}, 4'b1111, 32'h8000_0000},
        // R3 broadcast
        '{4'b0001, {32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF}, 4'b1111, 32'hFFFF_FFFF},
        // R3 scattered multicast
        '{4'b0001, {32'h0, 32'h0, 32'h0, 32'hA5A5_0F01}, 4'b1111, 32'hA5A5_0F01},
        // R5 four disjoint lanes
        '{4'b1111, {32'hFF00_0000, 32'h00FF_0000, 32'h0000_FF00, 32'h0000_00FF}, 4'b1111, 32'hFFFF_FFFF},
        // R6 overlap, lane 1 blocked
        '{4'b0011, {32'h0, 32'h0, 32'h0000_0018, 32'h0000_000F}, 4'b1101, 32'h0000_000F},
        // R7 blocked lane blocks nobody
        '{4'b1111, {32'h0000_0001, 32'h0000_0004, 32'h0000_0006, 32'h0000_0003}, 4'b0101, 32'h0000_0007},
        // R4 zero mask
        '{4'b0001, {32'h0, 32'h0, 32'h0, 32'h0}, 4'b1111, 32'h0},
        // R7 invalid lane 0 with full mask does not block lane 1
        '{4'b0010, {32'h0, 32'h0, 32'h0000_0001, 32'hFFFF_FFFF}, 4'b1111, 32'h0000_0001}
    };

    function automatic logic [DW-1:0] dval(input int i, input int k);
        return DW'((i + 1) * 256 + k * 17 + 3);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        in_vld = '0; in_mask = '0; in_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(leaf_vld == '0, "R1 in reset", 64'(leaf_vld), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(leaf_vld == '0, "R1 after release", 64'(leaf_vld), 64'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t t;
            bit ok;
            logic [DW-1:0] e, a;
            t = VECS[i];
            @(negedge clk);
            in_vld  = t.v;
            in_mask = t.m;
            for (int k = 0; k < B; k++) in_data[k] = dval(i, k);
            #1;
            check(in_rdy == t.rdy, $sformatf("R6/R7 ready vec %0d", i), 64'(in_rdy), 64'(t.rdy));
            @(posedge clk);
            @(negedge clk);
            clear_in();
            repeat (LV - 1) @(posedge clk);
            @(negedge clk);
            check(leaf_vld == t.lv, $sformatf("R2/R3 leaf valid vec %0d", i), 64'(leaf_vld), 64'(t.lv));
            ok = 1'b1; e = '0; a = '0;
            for (int n = 0; n < N; n++) begin
                if (t.lv[n]) begin
                    logic [DW-1:0] want;
                    want = '0;
                    for (int k = B - 1; k >= 0; k--)
                        if (t.v[k] && t.rdy[k] && t.m[k][n]) want = dval(i, k);
                    if (leaf_data[n] !== want && ok) begin
                        ok = 1'b0; e = want; a = leaf_data[n];
                    end
                end
            end
            check(ok, $sformatf("R10 leaf data vec %0d", i), 64'(a), 64'(e));
            @(negedge clk);
            check(leaf_vld == '0, $sformatf("R2 one-cycle vec %0d", i), 64'(leaf_vld), 64'h0);
        end

        // R8 all lanes fight for every leaf
        @(negedge clk);
        in_vld = '1;
        for (int k = 0; k < B; k++) begin
            in_mask[k] = '1;
            in_data[k] = dval(50, k);
        end
        #1;
        check(in_rdy == 4'b0001, "R8 lane0 wins all", 64'(in_rdy), 64'h1);
        @(posedge clk);
        @(negedge clk);
        clear_in();
        repeat (LV - 1) @(posedge clk);
        @(negedge clk);
        check(leaf_vld == '1 && leaf_data[17] == dval(50, 0), "R8 lane0 delivered",
              64'(leaf_data[17]), 64'(dval(50, 0)));

        // R9 back-to-back words
        @(negedge clk);
        in_vld = 4'b0001; in_mask[0] = 32'h20; in_data[0] = 16'hBEE1;
        @(posedge clk);
        @(negedge clk);
        in_mask[0] = 32'h20; in_data[0] = 16'hBEE2;
        @(posedge clk);
        @(negedge clk);
        in_mask[0] = 32'h40; in_data[0] = 16'hBEE3;
        @(posedge clk);
        @(negedge clk);
        clear_in();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(leaf_vld == 32'h20 && leaf_data[5] == 16'hBEE1, "R9 first", 64'(leaf_data[5]), 64'hBEE1);
        @(negedge clk);
        check(leaf_vld == 32'h20 && leaf_data[5] == 16'hBEE2, "R9 second", 64'(leaf_data[5]), 64'hBEE2);
        @(negedge clk);
        check(leaf_vld == 32'h40 && leaf_data[6] == 16'hBEE3, "R9 third", 64'(leaf_vld), 64'h40);
        @(negedge clk);
        check(leaf_vld == '0, "R9 drained", 64'(leaf_vld), 64'h0);

        // R1 reset while in flight
        @(negedge clk);
        in_vld = 4'b0001; in_mask[0] = '1; in_data[0] = 16'h7777;
        @(posedge clk);
        @(negedge clk);
        clear_in();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < LV + 1; w++) begin
            @(negedge clk);
            check(leaf_vld == '0, $sformatf("R1 flight flushed %0d", w), 64'(leaf_vld), 64'h0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule